// File: doc/BRIEF.md
# Cross-Domain Data Hold-Time Monitor

This block watches a multi-bit bus that is launched from a source clock domain and captured in a destination clock domain. Each time the bus takes a new value, the monitor requires that value to stay put until the destination clock has made three transitions. Rising and falling transitions both count. The bus itself is sampled only on the source clock, so a short-lived change between two slow destination edges is still seen.

In the destination domain, one flop flips on every rising edge and another flips on every falling edge. Their exclusive-OR is a level that changes on every destination transition. A two-stage synchronizer carries this level into the source domain, where a small controller counts its changes. If the bus changes again before the count is reached, the monitor pulses an error for one source cycle and restarts the window from the new value. If the count completes first, it pulses a pass and goes idle. The busy flag is high while a window is open.

The synchronizer delay makes the monitor slightly pessimistic. A window may stay open a few source cycles longer than strictly needed, and two destination edges that fall inside one source cycle may cancel out. Both effects only delay a pass and never hide a real violation.

Top module: `cdc_edge_window_mon`

## Requirements
- R1: After the source reset is released, err_o, pass_o and busy_o are low. The first bus value sampled after release becomes the reference and does not open a window, even if it differs from the value held during reset.
- R2: When a source rising edge samples a bus value different from the one sampled on the previous source edge, busy_o is high right after that edge.
- R3: A destination rising-falling-rising sequence is counted as three edges. After only two of them the window stays open, and after the third it closes with a pass.
- R4: A destination falling-rising-falling sequence also closes the window with a pass after its third edge, and not after its second.
- R5: pass_o is high for exactly one source cycle, and busy_o is low from that same cycle on.
- R6: A bus change while the window is open raises err_o for exactly one source cycle. busy_o stays high in that cycle, and err_o and pass_o are never high together.
- R7: After an error, the edge count restarts from zero. Edges seen before the offending change do not count toward closing the new window.
- R8: While no window is open, re-sampling an unchanged bus value opens no window and produces no pass or error.
- R9: With both clocks free-running (source period 8, destination period 12.8), every window ends in exactly one outcome. A window is always an error when the next change comes within three source cycles. It is always a pass when the bus is held for twelve or more source cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source clock; the bus is sampled on its rising edge |
| src_rst_n | input | 1 | Active-low reset, synchronous to src_clk |
| dst_clk | input | 1 | Destination clock; both of its edges are counted |
| dst_rst_n | input | 1 | Active-low reset, synchronous to dst_clk |
| data_in | input | DATA_W | Bus under observation, launched in the source domain |
| err_o | output | 1 | One-cycle pulse: bus changed before the window closed |
| pass_o | output | 1 | One-cycle pulse: window closed with the bus unchanged |
| busy_o | output | 1 | High while a hold window is open |

## Verification
The hardest cases to reach are the ones that depend on a precise count of destination edges. With free-running clocks, the phase between the two domains decides whether a window closes in time, and it blurs the difference between two edges and three. To remove that uncertainty, the bench stops the destination clock and drives it by hand, one edge at a time, with several source cycles between edges. It then places bus changes between those single edges to test the three-edge threshold, the handling of both polarities and the restart of the count after an error. A sweep over hold lengths with free-running clocks and shifted start phases then covers the cases whose outcome is fixed and checks that every other window ends exactly once.

// File: rtl/cdcmon_pkg.sv
package cdcmon_pkg;

    // Life cycle of one hold window in the source domain
    typedef enum logic [1:0] {
        PH_UNPRIMED = 2'd0,   // reference not yet captured after reset
        PH_IDLE     = 2'd1,   // reference held, no window open
        PH_OPEN     = 2'd2    // waiting for destination edges
    } win_phase_e;

endpackage

// File: rtl/dst_edge_flip.sv
// Destination-domain level that changes on every edge of clk.
module dst_edge_flip (
    input  logic clk,
    input  logic rst_n,
    output logic level_o
);
    logic rise_d, rise_q;
    logic fall_d, fall_q;

    always_comb begin
        rise_d = ~rise_q;
        fall_d = ~fall_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fall_d;
    end

    assign level_o = rise_q ^ fall_q;
endmodule

// File: rtl/level_sync.sv
// Plain multi-stage synchronizer for a single level.
module level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hold_window_ctrl.sv
// Source-domain window controller: detects bus changes and counts
// synchronized destination-edge events.
module hold_window_ctrl
    import cdcmon_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int EDGE_COUNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              lvl_i,
    output logic              err_o,
    output logic              pass_o,
    output logic              busy_o
);
    localparam int CW = $clog2(EDGE_COUNT + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(EDGE_COUNT - 1);

    typedef struct packed {
        win_phase_e        phase;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] ref_v;
        logic              lvl_prev;
        logic              err;
        logic              pass;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    step;
    logic    moved;

    always_comb begin
        st_d          = st_q;
        st_d.err      = 1'b0;
        st_d.pass     = 1'b0;
        st_d.lvl_prev = lvl_i;
        st_d.ref_v    = data_i;
        step          = lvl_i ^ st_q.lvl_prev;
        moved         = (data_i != st_q.ref_v);

        unique case (st_q.phase)
            PH_UNPRIMED: begin
                st_d.phase = PH_IDLE;
            end
            PH_IDLE: begin
                if (moved) begin
                    st_d.phase = PH_OPEN;
                    st_d.cnt   = '0;
                end
            end
            PH_OPEN: begin
                if (moved) begin
                    st_d.err = 1'b1;
                    st_d.cnt = '0;
                end else if (step) begin
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.phase = PH_IDLE;
                        st_d.pass  = 1'b1;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                st_d.phase = PH_UNPRIMED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o  = st_q.err;
    assign pass_o = st_q.pass;
    assign busy_o = (st_q.phase == PH_OPEN);
endmodule

// File: rtl/cdc_edge_window_mon.sv
module cdc_edge_window_mon #(
    parameter int DATA_W      = 8,
    parameter int EDGE_COUNT  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              err_o,
    output logic              pass_o,
    output logic              busy_o
);
    logic dst_level;
    logic src_level;

    dst_edge_flip u_flip (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .level_o (dst_level)
    );

    level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d_i   (dst_level),
        .q_o   (src_level)
    );

    hold_window_ctrl #(
        .DATA_W     (DATA_W),
        .EDGE_COUNT (EDGE_COUNT)
    ) u_ctrl (
        .clk    (src_clk),
        .rst_n  (src_rst_n),
        .data_i (data_in),
        .lvl_i  (src_level),
        .err_o  (err_o),
        .pass_o (pass_o),
        .busy_o (busy_o)
    );
endmodule

// File: rtl/cdcmon_checker.sv
module cdcmon_checker #(
    parameter int DATA_W = 8
) (
    input logic              src_clk,
    input logic              src_rst_n,
    input logic [DATA_W-1:0] data_in,
    input logic              err_o,
    input logic              pass_o,
    input logic              busy_o
);
    // source edges seen since reset, saturating at 2
    logic [1:0] seen_q;
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)        seen_q <= 2'd0;
        else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
    end

    p_opens_on_change_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        ($rose(busy_o) && seen_q == 2'd2) |-> ($past(data_in) != $past(data_in, 2)));

    p_pass_after_open_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (pass_o && seen_q == 2'd2) |-> $past(busy_o));

    p_pass_single_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        pass_o |=> !pass_o);

    p_pass_drops_busy_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        pass_o |-> !busy_o);

    p_err_keeps_busy_r6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        err_o |-> busy_o);

    p_err_single_r6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        err_o |=> !err_o);

    p_err_pass_excl_r6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !(err_o && pass_o));

    p_same_value_idle_r8: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (seen_q != 2'd0 && !busy_o && data_in == $past(data_in)) |=> (!busy_o && !err_o));
endmodule

bind cdc_edge_window_mon cdcmon_checker #(.DATA_W(DATA_W)) u_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .data_in   (data_in),
    .err_o     (err_o),
    .pass_o    (pass_o),
    .busy_o    (busy_o)
);

// File: tb/sim_cdc_edge_window_mon.sv
`timescale 1ns/1ps
module sim_cdc_edge_window_mon;
    localparam int DW = 8;

    logic          src_clk = 1'b0;
    logic          dst_free = 1'b0;
    logic          dst_man = 1'b0;
    logic          manual = 1'b0;
    logic          dst_clk;
    logic          src_rst_n = 1'b0;
    logic          dst_rst_n = 1'b0;
    logic [DW-1:0] data = 8'hA5;
    logic          err_o, pass_o, busy_o;

    int checks = 0;
    int errors = 0;

    always #4   src_clk  = ~src_clk;   // 125 MHz
    always #6.4 dst_free = ~dst_free;  // ratio 1.6
    assign dst_clk = manual ? dst_man : dst_free;

    cdc_edge_window_mon #(.DATA_W(DW)) u0 (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .data_in   (data),
        .err_o     (err_o),
        .pass_o    (pass_o),
        .busy_o    (busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // watch n source cycles, sampled at falling src edges
    task automatic watch(input int n, output int np, output int ne);
        np = 0; ne = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge src_clk);
            np += int'(pass_o);
            ne += int'(err_o);
        end
    endtask

    task automatic man_edge(input logic v);
        @(negedge src_clk);
        dst_man = v;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int np, ne;
        logic [DW-1:0] val;
        repeat (6) @(negedge src_clk);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        data = 8'h3C;   // differs from reset-time value, must only prime (R1)

        @(negedge src_clk);
        check(!err_o && !pass_o && !busy_o, "R1 outputs after reset", {err_o, pass_o, busy_o}, 0);
        watch(5, np, ne);
        check(!busy_o && np == 0 && ne == 0, "R1 first value only primes", int'(busy_o) + np + ne, 0);

        // R8: rewrite the same value repeatedly
        for (int i = 0; i < 4; i++) begin
            @(negedge src_clk);
            data = 8'h3C;
        end
        watch(4, np, ne);
        check(!busy_o && np == 0 && ne == 0, "R8 unchanged value idle", int'(busy_o) + np + ne, 0);

        // switch destination clock to manual while it is low
        @(negedge dst_free);
        dst_man = 1'b0;
        manual  = 1'b1;
        watch(4, np, ne);

        // R3: rise, fall, rise
        @(negedge src_clk); data = 8'h11;
        @(negedge src_clk);
        check(busy_o == 1'b1, "R2 window opens on change", busy_o, 1);
        man_edge(1'b1); watch(5, np, ne);
        man_edge(1'b0); watch(5, np, ne);
        check(busy_o && np == 0 && ne == 0, "R3 two edges keep window open", int'(busy_o), 1);
        man_edge(1'b1);
        watch(6, np, ne);
        check(np == 1, "R3 third edge gives one pass (R5)", np, 1);
        check(!busy_o && ne == 0, "R5 busy low after pass", int'(busy_o), 0);

        // R4: fall, rise, fall (dst_man is now high)
        @(negedge src_clk); data = 8'h22;
        @(negedge src_clk);
        check(busy_o == 1'b1, "R2 window opens again", busy_o, 1);
        man_edge(1'b0); watch(5, np, ne);
        man_edge(1'b1); watch(5, np, ne);
        check(busy_o && np == 0, "R4 two edges keep window open", np, 0);
        man_edge(1'b0);
        watch(6, np, ne);
        check(np == 1 && !busy_o, "R4 third edge gives pass", np, 1);

        // R6/R7: error then restart (dst_man is low)
        @(negedge src_clk); data = 8'h33;
        man_edge(1'b1); watch(5, np, ne);
        man_edge(1'b0); watch(5, np, ne);
        @(negedge src_clk); data = 8'h44;
        @(negedge src_clk);
        check(err_o == 1'b1, "R6 early change flags error", err_o, 1);
        check(busy_o == 1'b1, "R6 busy stays high on error", busy_o, 1);
        watch(4, np, ne);
        check(ne == 0, "R6 error lasts one cycle", ne, 0);
        man_edge(1'b1); watch(6, np, ne);
        check(np == 0 && busy_o, "R7 count restarted after error", np, 0);
        man_edge(1'b0); watch(5, np, ne);
        check(np == 0 && busy_o, "R7 two fresh edges not enough", np, 0);
        man_edge(1'b1); watch(6, np, ne);
        check(np == 1 && !busy_o, "R7 third fresh edge passes", np, 1);

        // back to free-running destination clock while it is low
        @(negedge dst_free);
        dst_man = 1'b0;
        manual  = 1'b0;
        watch(20, np, ne);

        // R9: sweep hold length and start phase
        val = 8'h50;
        for (int ph = 0; ph < 3; ph++) begin
            for (int g = 1; g <= 14; g++) begin
                int p_in, e_out, dummy;
                watch(20 + ph, np, ne);   // let previous window close
                @(negedge src_clk); val = val + 8'd1; data = val;
                watch(g, p_in, ne);
                val = val + 8'd1; data = val;
                @(negedge src_clk);
                e_out = int'(err_o);
                if (g <= 3)
                    check(p_in == 0 && e_out == 1, "R9 short hold errors", p_in * 10 + e_out, 1);
                else if (g >= 12)
                    check(p_in == 1 && e_out == 0, "R9 long hold passes", p_in * 10 + e_out, 10);
                else
                    check(p_in + e_out == 1, "R9 exactly one outcome", p_in + e_out, 1);
                watch(1, dummy, ne);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule